// File: doc/BRIEF.md
# Shared Auxiliary RAM Window Mapper

This block lets any core in an eight-core cluster read and write part of another core's private auxiliary RAM with an ordinary shared-memory access. A 4 KB hole in the shared address space is split into one fixed 512-byte slice per core. A slice is backed by the upper 128 words of that core's auxiliary RAM. The auxiliary RAMs are modelled inside the block as dual-ported arrays. One port belongs to the owning core. The other port serves requests that arrive from the shared-memory side.

Each core opts in to sharing. After reset every slice is closed. A core opens or closes its own slice with a single-cycle control strobe. A shared request that lands in a closed slice reads zero, changes nothing, and raises an error pulse. Because each core owns a fixed part of the hole, two cores can never map onto the same shared address. The only write conflict left is between a core and a shared request touching the same word in the same cycle. In that case the core's own write is kept.

Top module: `aux_window_map`

## Requirements
- R1: `sh_hit` is high exactly when `sh_req` is high and `sh_addr[ADDR_W-1:12]` equals the hole base (default 0). A request outside the hole produces no `sh_rvalid`, no `sh_err` and no RAM change.
- R2: Inside the hole, `sh_addr[11:9]` selects the core and `sh_addr[8:2]` selects word w of that core's slice. Word w is local auxiliary address 128+w. `sh_addr[1:0]` is ignored.
- R3: A shared read in the hole at clock edge N raises `sh_rvalid` for the cycle after edge N. If the slice is open, `sh_rdata` carries the selected word in that cycle.
- R4: After reset all slices are closed and `sh_rvalid` and `sh_err` are low.
- R5: `share_wr[i]` loads `share_on[i]` into core i's open flag at the clock edge. Requests sampled at later edges see the new value.
- R6: A read of a closed slice returns zero. A write to a closed slice leaves the RAM unchanged.
- R7: `sh_err` is high for exactly the one cycle after a hole access (read or write) to a closed slice, and is low otherwise.
- R8: A shared write updates byte k (bits 8k+7:8k) only where `sh_be[k]` is 1.
- R9: Each core's local port reads and writes all 256 of its words with one-cycle read latency, whatever the sharing state. The lower 128 words are never reachable from the shared side.
- R10: If a core's local write and a shared write hit the same word in the same cycle, the word ends up holding the local data in full.
- R11: A read of a word that is written in the same cycle, on either port, returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_en | input | NUM_CORES | Per-core local access strobe |
| loc_we | input | NUM_CORES | Per-core local write (1) or read (0) |
| loc_addr | input | NUM_CORES*8 | Per-core local word address, core i at bits [8i+7:8i] |
| loc_wdata | input | NUM_CORES*32 | Per-core local write data |
| loc_rdata | output | NUM_CORES*32 | Per-core local read data, one cycle after the read |
| share_wr | input | NUM_CORES | Strobe that loads a core's open flag |
| share_on | input | NUM_CORES | Value loaded by `share_wr` (1 opens the slice) |
| sh_req | input | 1 | Shared-side request valid |
| sh_we | input | 1 | Shared-side write (1) or read (0) |
| sh_addr | input | 18 | Shared byte address |
| sh_be | input | 4 | Shared write byte enables |
| sh_wdata | input | 32 | Shared write data |
| sh_hit | output | 1 | Request falls in the hole (combinational) |
| sh_rvalid | output | 1 | Shared read data valid |
| sh_rdata | output | 32 | Shared read data |
| sh_err | output | 1 | Access to a closed slice, one-cycle pulse |

## Verification
The bench aims at the same-word collision between a core and the shared side. A design that let the shared write win, or merged its bytes into the result, would leave shared bytes in the word. It also tests a read and a write to the same word in one cycle, where a write-through RAM would return the new value instead of the old one. Writes to a closed slice are checked by reopening the slice and reading back. A leaky gate would show the written data there. Partial byte enables, the top word of the last core, and set low address bits are aimed at decode mistakes, which would hit the wrong word or the wrong core. Addresses just outside the hole must produce no response at all.

// File: rtl/aux_win_pkg.sv
package aux_win_pkg;

   localparam int unsigned BYTE_W = 8;

   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_e;

endpackage

// File: rtl/aux_win_decode.sv
module aux_win_decode
   import aux_win_pkg::*;
#(
   parameter int unsigned ADDR_W    = 18,
   parameter int unsigned HOLE_BASE = 0,
   parameter int unsigned NUM_CORES = 8,
   parameter int unsigned WIN_WORDS = 128,
   parameter int unsigned OFS_LSB   = 2,
   localparam int unsigned CORE_B   = $clog2(NUM_CORES),
   localparam int unsigned WORD_B   = $clog2(WIN_WORDS),
   localparam int unsigned SPAN_B   = OFS_LSB + WORD_B + CORE_B
) (
   input  logic                 req,
   input  logic                 we,
   input  logic [ADDR_W-1:0]    addr,
   output logic                 hit,
   output acc_e                 kind,
   output logic [NUM_CORES-1:0] core_sel,
   output logic [WORD_B-1:0]    word
);

   localparam logic [ADDR_W-1:0] BASE_V = HOLE_BASE[ADDR_W-1:0];

   logic [CORE_B-1:0] core_idx;

   assign hit      = req && (addr[ADDR_W-1:SPAN_B] == BASE_V[ADDR_W-1:SPAN_B]);
   assign core_idx = addr[SPAN_B-1 -: CORE_B];
   assign word     = addr[OFS_LSB +: WORD_B];

   always_comb begin
      if (!hit)    kind = ACC_NONE;
      else if (we) kind = ACC_WRITE;
      else         kind = ACC_READ;
   end

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_sel
      assign core_sel[c] = hit && (core_idx == CORE_B'(c));
   end

endmodule

// File: rtl/aux_win_bank.sv
module aux_win_bank
   import aux_win_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned WIN_WORDS = 128,
   localparam int unsigned BE_W     = DATA_W / BYTE_W,
   localparam int unsigned WORD_B   = $clog2(WIN_WORDS),
   localparam int unsigned DEPTH    = 2 * WIN_WORDS,
   localparam int unsigned LOC_AW   = WORD_B + 1
) (
   input  logic              clk,
   input  logic              loc_en,
   input  logic              loc_we,
   input  logic [LOC_AW-1:0] loc_addr,
   input  logic [DATA_W-1:0] loc_wdata,
   output logic [DATA_W-1:0] loc_rdata,
   input  logic              sh_en,
   input  logic              sh_we,
   input  logic [WORD_B-1:0] sh_word,
   input  logic [BE_W-1:0]   sh_be,
   input  logic [DATA_W-1:0] sh_wdata,
   output logic [DATA_W-1:0] sh_rdata
);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [LOC_AW-1:0] sh_idx;

   // the shared side only ever reaches the upper half
   assign sh_idx = {1'b1, sh_word};

   // reads sample the array before this edge's writes land (read-first);
   // the local write is issued last so it overrides a same-word shared write
   always_ff @(posedge clk) begin
      if (loc_en && !loc_we) loc_rdata <= mem[loc_addr];
      if (sh_en && !sh_we)   sh_rdata  <= mem[sh_idx];
      if (sh_en && sh_we) begin
         for (int b = 0; b < BE_W; b++) begin
            if (sh_be[b]) mem[sh_idx][b*BYTE_W +: BYTE_W] <= sh_wdata[b*BYTE_W +: BYTE_W];
         end
      end
      if (loc_en && loc_we) mem[loc_addr] <= loc_wdata;
   end

endmodule

// File: rtl/aux_win_gate.sv
module aux_win_gate
   import aux_win_pkg::*;
#(
   parameter int unsigned NUM_CORES = 8,
   parameter int unsigned DATA_W    = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_CORES-1:0]          share_wr,
   input  logic [NUM_CORES-1:0]          share_on,
   input  logic                          hit,
   input  acc_e                          kind,
   input  logic [NUM_CORES-1:0]          core_sel,
   input  logic [NUM_CORES*DATA_W-1:0]   bank_rdata,
   output logic [NUM_CORES-1:0]          bank_en,
   output logic                          rvalid,
   output logic                          err,
   output logic [DATA_W-1:0]             rdata
);

   logic [NUM_CORES-1:0] open_q;
   logic [NUM_CORES-1:0] rsel_q;
   logic                 rd_q;
   logic                 err_q;
   logic                 closed_hit;

   assign bank_en    = core_sel & open_q;
   assign closed_hit = hit && ((core_sel & open_q) == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= '0;
         rsel_q <= '0;
         rd_q   <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         open_q <= (open_q & ~share_wr) | (share_on & share_wr);
         rd_q   <= (kind == ACC_READ);
         rsel_q <= (kind == ACC_READ) ? (core_sel & open_q) : '0;
         err_q  <= closed_hit;
      end
   end

   // AND-OR mux: an empty select (closed slice) yields zero
   logic [DATA_W-1:0] part [NUM_CORES+1];
   assign part[0] = '0;
   for (genvar c = 0; c < NUM_CORES; c++) begin : g_mux
      assign part[c+1] = part[c] | (bank_rdata[c*DATA_W +: DATA_W] & {DATA_W{rsel_q[c]}});
   end

   assign rdata  = part[NUM_CORES];
   assign rvalid = rd_q;
   assign err    = err_q;

endmodule

// File: rtl/aux_window_map.sv
module aux_window_map
   import aux_win_pkg::*;
#(
   parameter int unsigned NUM_CORES = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned WIN_WORDS = 128,
   parameter int unsigned ADDR_W    = 18,
   parameter int unsigned HOLE_BASE = 0,
   localparam int unsigned BE_W     = DATA_W / BYTE_W,
   localparam int unsigned OFS_LSB  = $clog2(BE_W),
   localparam int unsigned WORD_B   = $clog2(WIN_WORDS),
   localparam int unsigned CORE_B   = $clog2(NUM_CORES),
   localparam int unsigned SPAN_B   = OFS_LSB + WORD_B + CORE_B,
   localparam int unsigned LOC_AW   = WORD_B + 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_CORES-1:0]        loc_en,
   input  logic [NUM_CORES-1:0]        loc_we,
   input  logic [NUM_CORES*LOC_AW-1:0] loc_addr,
   input  logic [NUM_CORES*DATA_W-1:0] loc_wdata,
   output logic [NUM_CORES*DATA_W-1:0] loc_rdata,
   input  logic [NUM_CORES-1:0]        share_wr,
   input  logic [NUM_CORES-1:0]        share_on,
   input  logic                        sh_req,
   input  logic                        sh_we,
   input  logic [ADDR_W-1:0]           sh_addr,
   input  logic [BE_W-1:0]             sh_be,
   input  logic [DATA_W-1:0]           sh_wdata,
   output logic                        sh_hit,
   output logic                        sh_rvalid,
   output logic [DATA_W-1:0]           sh_rdata,
   output logic                        sh_err
);

   if (DATA_W % BYTE_W != 0 || BE_W < 1) begin : g_bad_width
      $error("DATA_W must be a whole number of bytes");
   end
   if ((1 << CORE_B) != NUM_CORES || NUM_CORES < 2) begin : g_bad_cores
      $error("NUM_CORES must be a power of two, at least 2");
   end
   if ((1 << WORD_B) != WIN_WORDS || (1 << OFS_LSB) != BE_W) begin : g_bad_win
      $error("WIN_WORDS and byte lanes must be powers of two");
   end
   if (ADDR_W > 32 || ADDR_W <= SPAN_B) begin : g_bad_addr
      $error("ADDR_W must exceed the hole span and be at most 32");
   end
   if (HOLE_BASE % (1 << SPAN_B) != 0) begin : g_bad_base
      $error("HOLE_BASE must be aligned to the hole size");
   end

   acc_e                        kind;
   logic [NUM_CORES-1:0]        core_sel;
   logic [WORD_B-1:0]           word;
   logic [NUM_CORES-1:0]        bank_en;
   logic [NUM_CORES*DATA_W-1:0] bank_rdata;

   aux_win_decode #(
      .ADDR_W(ADDR_W), .HOLE_BASE(HOLE_BASE), .NUM_CORES(NUM_CORES),
      .WIN_WORDS(WIN_WORDS), .OFS_LSB(OFS_LSB)
   ) i_decode (
      .req(sh_req), .we(sh_we), .addr(sh_addr),
      .hit(sh_hit), .kind(kind), .core_sel(core_sel), .word(word)
   );

   aux_win_gate #(.NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) i_gate (
      .clk(clk), .rst_n(rst_n), .share_wr(share_wr), .share_on(share_on),
      .hit(sh_hit), .kind(kind), .core_sel(core_sel), .bank_rdata(bank_rdata),
      .bank_en(bank_en), .rvalid(sh_rvalid), .err(sh_err), .rdata(sh_rdata)
   );

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_bank
      aux_win_bank #(.DATA_W(DATA_W), .WIN_WORDS(WIN_WORDS)) i_bank (
         .clk(clk),
         .loc_en(loc_en[c]),
         .loc_we(loc_we[c]),
         .loc_addr(loc_addr[c*LOC_AW +: LOC_AW]),
         .loc_wdata(loc_wdata[c*DATA_W +: DATA_W]),
         .loc_rdata(loc_rdata[c*DATA_W +: DATA_W]),
         .sh_en(bank_en[c]),
         .sh_we(sh_we),
         .sh_word(word),
         .sh_be(sh_be),
         .sh_wdata(sh_wdata),
         .sh_rdata(bank_rdata[c*DATA_W +: DATA_W])
      );
   end

endmodule

// File: rtl/aux_window_map_chk.sv
module aux_window_map_chk #(
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sh_req,
   input logic              sh_we,
   input logic              sh_hit,
   input logic              sh_rvalid,
   input logic              sh_err,
   input logic [DATA_W-1:0] sh_rdata
);

   // R1
   miss_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_req && !sh_hit) |=> (!sh_rvalid && !sh_err));

   // R3
   rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sh_rvalid |-> $past(sh_req && !sh_we && sh_hit));

   // R4
   closed_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!rst_n) && sh_hit) |=> sh_err);

   // R6
   closed_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_rvalid && sh_err) |-> (sh_rdata == '0));

   // R7
   err_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sh_err |-> $past(sh_hit));

endmodule

bind aux_window_map aux_window_map_chk #(.DATA_W(DATA_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .sh_req(sh_req), .sh_we(sh_we), .sh_hit(sh_hit),
   .sh_rvalid(sh_rvalid), .sh_err(sh_err), .sh_rdata(sh_rdata)
);

// File: tb/test_aux_window_map.sv
`timescale 1ns/1ps
module test_aux_window_map;

   localparam int NC = 8;
   localparam int DW = 32;
   localparam int AW = 18;
   localparam int LA = 8;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [NC-1:0]     loc_en, loc_we;
   logic [NC*LA-1:0]  loc_addr;
   logic [NC*DW-1:0]  loc_wdata, loc_rdata;
   logic [NC-1:0]     share_wr, share_on;
   logic              sh_req, sh_we;
   logic [AW-1:0]     sh_addr;
   logic [3:0]        sh_be;
   logic [DW-1:0]     sh_wdata, sh_rdata;
   logic              sh_hit, sh_rvalid, sh_err;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   logic [DW-1:0] mdl [NC][256];
   bit            mopen [NC];

   always #2.5 clk = ~clk;

   aux_window_map i_aux_window_map (
      .clk(clk), .rst_n(rst_n), .loc_en(loc_en), .loc_we(loc_we),
      .loc_addr(loc_addr), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
      .share_wr(share_wr), .share_on(share_on), .sh_req(sh_req), .sh_we(sh_we),
      .sh_addr(sh_addr), .sh_be(sh_be), .sh_wdata(sh_wdata), .sh_hit(sh_hit),
      .sh_rvalid(sh_rvalid), .sh_rdata(sh_rdata), .sh_err(sh_err)
   );

   task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit in_hole(input logic [AW-1:0] a, input logic r);
      return r && (a[AW-1:12] == '0);
   endfunction

   function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                          input logic [DW-1:0] nw, input logic [3:0] be);
      logic [DW-1:0] r = old;
      for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
      return r;
   endfunction

   task automatic idle();
      loc_en = '0; loc_we = '0; loc_addr = '0; loc_wdata = '0;
      share_wr = '0; share_on = '0;
      sh_req = 0; sh_we = 0; sh_addr = '0; sh_be = '0; sh_wdata = '0;
   endtask

   task automatic set_loc(input int c, input bit w, input logic [7:0] a, input logic [DW-1:0] d);
      loc_en[c] = 1'b1; loc_we[c] = w;
      loc_addr[c*LA +: LA] = a; loc_wdata[c*DW +: DW] = d;
   endtask

   task automatic set_sh(input bit w, input logic [AW-1:0] a, input logic [3:0] be,
                         input logic [DW-1:0] d);
      sh_req = 1; sh_we = w; sh_addr = a; sh_be = be; sh_wdata = d;
   endtask

   // inputs are set at a falling edge; one rising edge; outputs checked at next falling edge
   task automatic step(input string t);
      bit e_hit, e_rv, e_err;
      logic [DW-1:0] e_rd;
      logic [DW-1:0] e_lr [NC];
      int core, w;
      #1;
      e_hit = in_hole(sh_addr, sh_req);
      chk(sh_hit == e_hit, (t != "") ? t : "R1", {31'b0, sh_hit}, {31'b0, e_hit});
      core  = int'(sh_addr[11:9]);
      w     = 128 + int'(sh_addr[8:2]);
      e_rv  = e_hit && !sh_we;
      e_err = e_hit && !mopen[core];
      e_rd  = (e_rv && mopen[core]) ? mdl[core][w] : '0;
      for (int c = 0; c < NC; c++) e_lr[c] = mdl[c][loc_addr[c*LA +: LA]];
      if (e_hit && sh_we && mopen[core]) mdl[core][w] = merge(mdl[core][w], sh_wdata, sh_be);
      for (int c = 0; c < NC; c++)
         if (loc_en[c] && loc_we[c]) mdl[c][loc_addr[c*LA +: LA]] = loc_wdata[c*DW +: DW];
      for (int c = 0; c < NC; c++) if (share_wr[c]) mopen[c] = share_on[c];
      @(posedge clk);
      @(negedge clk);
      chk(sh_rvalid == e_rv, (t != "") ? t : "R3", {31'b0, sh_rvalid}, {31'b0, e_rv});
      chk(sh_err == e_err, (t != "") ? t : "R7", {31'b0, sh_err}, {31'b0, e_err});
      if (e_rv) chk(sh_rdata === e_rd, (t != "") ? t : (e_err ? "R6" : "R3"), sh_rdata, e_rd);
      for (int c = 0; c < NC; c++)
         if (loc_en[c] && !loc_we[c])
            chk(loc_rdata[c*DW +: DW] === e_lr[c], (t != "") ? t : "R9",
                loc_rdata[c*DW +: DW], e_lr[c]);
      idle();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      idle();
      for (int c = 0; c < NC; c++) mopen[c] = 0;
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R4: outputs quiet out of reset
      chk(sh_rvalid == 0, "R4", {31'b0, sh_rvalid}, 32'd0);
      chk(sh_err == 0, "R4", {31'b0, sh_err}, 32'd0);

      // R9: preload every word of every core through the local ports
      for (int a = 0; a < 256; a++) begin
         for (int c = 0; c < NC; c++) set_loc(c, 1, 8'(a), {8'(c), 8'(a), 16'hA5C3 ^ 16'(a * 37)});
         step("R9");
      end
      for (int a = 0; a < 256; a += 17) begin
         for (int c = 0; c < NC; c++) set_loc(c, 0, 8'(a), '0);
         step("R9");
      end

      // R4: every slice closed after reset
      for (int c = 0; c < NC; c++) begin
         set_sh(0, {6'b0, 3'(c), 7'd3, 2'b00}, 4'hF, '0);
         step("R4");
      end

      // R5: open core 3 then read it
      share_wr[3] = 1; share_on[3] = 1; set_sh(0, {6'b0, 3'd3, 7'd5, 2'b00}, 4'hF, '0);
      step("R5");
      set_sh(0, {6'b0, 3'd3, 7'd5, 2'b00}, 4'hF, '0);
      step("R5");
      share_wr = '1; share_on = '1;
      step("R5");

      // R2: decode corners, low address bits ignored
      set_sh(0, {6'b0, 3'd7, 7'd127, 2'b11}, 4'hF, '0); step("R2");
      set_sh(0, {6'b0, 3'd0, 7'd0, 2'b01}, 4'hF, '0);   step("R2");
      set_sh(0, {6'b0, 3'd5, 7'd64, 2'b10}, 4'hF, '0);  step("R2");

      // R8: partial byte enables
      set_sh(1, {6'b0, 3'd1, 7'd9, 2'b00}, 4'b0101, 32'h1122_3344); step("R8");
      set_sh(0, {6'b0, 3'd1, 7'd9, 2'b00}, 4'hF, '0);               step("R8");
      set_sh(1, {6'b0, 3'd2, 7'd9, 2'b00}, 4'b1000, 32'hDEAD_BEEF); step("R8");
      set_sh(0, {6'b0, 3'd2, 7'd9, 2'b00}, 4'hF, '0);               step("R8");

      // R10: same-word collision, local wins
      set_loc(4, 1, 8'd148, 32'h0BAD_F00D);
      set_sh(1, {6'b0, 3'd4, 7'd20, 2'b00}, 4'hF, 32'hFFFF_FFFF); step("R10");
      set_sh(0, {6'b0, 3'd4, 7'd20, 2'b00}, 4'hF, '0);            step("R10");

      // R11: read-first on both ports
      set_loc(5, 1, 8'd135, 32'h5555_0001);
      set_sh(0, {6'b0, 3'd5, 7'd7, 2'b00}, 4'hF, '0); step("R11");
      set_loc(6, 0, 8'd130, '0);
      set_sh(1, {6'b0, 3'd6, 7'd2, 2'b00}, 4'hF, 32'h6666_0002); step("R11");

      // R6: closed slice swallows writes, reads zero
      share_wr[6] = 1; share_on[6] = 0; step("R6");
      set_sh(1, {6'b0, 3'd6, 7'd11, 2'b00}, 4'hF, 32'hCAFE_0000); step("R6");
      set_sh(0, {6'b0, 3'd6, 7'd11, 2'b00}, 4'hF, '0);            step("R6");
      share_wr[6] = 1; share_on[6] = 1; step("R6");
      set_sh(0, {6'b0, 3'd6, 7'd11, 2'b00}, 4'hF, '0);            step("R6");

      // R1: just outside the hole
      set_sh(0, 18'h01000, 4'hF, '0);            step("R1");
      set_sh(1, 18'h01004, 4'hF, 32'h1234_5678); step("R1");
      set_sh(0, 18'h3F000, 4'hF, '0);            step("R1");
      set_sh(0, {6'b0, 3'd0, 7'd1, 2'b00}, 4'hF, '0); step("R1");

      // random traffic
      for (int i = 0; i < 3000; i++) begin
         logic [AW-1:0] a;
         a = ($urandom % 10 < 8) ? {6'b0, 12'($urandom)} : 18'($urandom);
         if ($urandom % 4 != 0)
            set_sh($urandom % 2, a, 4'($urandom), $urandom);
         for (int c = 0; c < NC; c++) begin
            if ($urandom % 3 == 0)
               set_loc(c, $urandom % 2,
                       ($urandom % 2) ? {1'b1, a[8:2]} : 8'($urandom), $urandom);
            if ($urandom % 16 == 0) begin
               share_wr[c] = 1; share_on[c] = ($urandom % 4 != 0);
            end
         end
         step("");
      end

      finish_run();
   end

endmodule